// File: doc/BRIEF.md
# Instrument Status Byte and Service Request Logic

This block assembles the 8-bit status byte of a remotely controlled instrument and decides when the instrument asks its controller for attention. Three status sources feed the byte. Two are level summaries that arrive from elsewhere: one for questionable data and one for standard events. The third is a message-available flag that the block holds itself. A pulse sets this flag when a query response enters the output buffer, and another pulse clears it once the output terminator has gone to the host.

An 8-bit enable mask, loaded through a one-cycle write strobe, picks which status bits may raise the summary. The byte can be read in two ways, and bit 6 differs between them. The query view carries the live summary, which is the OR of every enabled status bit. The serial-poll view carries a latched request flag. This flag is set by a rising summary or by a front-panel request, and a poll strobe clears it. The request flag also drives the active-high service request line.

Top module: `svc_status_core`

## Requirements
- R1: Bits 0, 1, 2 and 7 of both the query byte and the poll byte are always 0.
- R2: Bit 3 of both bytes equals the questionable-data summary input and bit 5 equals the standard-event summary input, in the same cycle, with no register in the path.
- R3: A message-available set pulse makes bit 4 read 1 from the cycle after the pulse. If the set pulse and the terminator-sent pulse arrive in the same cycle, bit 4 reads 1 afterwards.
- R4: A terminator-sent pulse alone makes bit 4 read 0 from the cycle after the pulse. Otherwise bit 4 holds its value.
- R5: A write strobe loads the 8-bit enable mask, which takes effect from the next cycle. Mask bit n enables status bit n, so a value of 16 enables only bit 4 and a value of 48 enables bits 4 and 5.
- R6: Bit 6 of the query byte is 1 exactly when some status bit other than bit 6 is 1 and its mask bit is also 1. Mask bit 6 has no effect.
- R7: The request flag becomes 1 in the cycle after the query summary rises from 0 to 1, or in the cycle after a front-panel pulse. Bit 6 of the poll byte and the service request line both show the request flag.
- R8: A poll strobe clears the request flag from the next cycle. A set condition in the same cycle wins over the poll. A summary that stays high does not set the flag again.
- R9: Synchronous active-high reset clears the enable mask, the message-available flag and the request flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ques_sum_i | input | 1 | Questionable-data summary level |
| evt_sum_i | input | 1 | Standard-event summary level |
| mav_set_i | input | 1 | Pulse: a response was placed in the output buffer |
| term_sent_i | input | 1 | Pulse: the output terminator was sent |
| panel_req_i | input | 1 | Pulse: front-panel service request |
| en_wr_i | input | 1 | Enable mask write strobe |
| en_wdata_i | input | 8 | Enable mask write value |
| poll_rd_i | input | 1 | Serial-poll strobe; clears the request flag |
| qry_byte_o | output | 8 | Status byte as seen by a query (bit 6 = summary) |
| poll_byte_o | output | 8 | Status byte as seen by a serial poll (bit 6 = request flag) |
| srq_o | output | 1 | Active-high service request line |

## Verification
The bench polls while the summary stays high. A design that re-arms on the summary level instead of its rising edge would raise the request line again straight after the poll. It sets mask bit 6 on its own with every status source high. A design that let the summary feed itself would report a request there. It also drives set and clear pulses for the message flag in the same cycle, and a poll together with a front-panel pulse, so a design with the wrong priority leaves the flag or the request cleared. Asserting every input during reset catches state that survives reset.

// File: rtl/svc_status_pkg.sv
package svc_status_pkg;

    localparam int BYTE_W   = 8;
    localparam int QUES_POS = 3;
    localparam int MAV_POS  = 4;
    localparam int EVT_POS  = 5;
    localparam int SUM_POS  = 6;

    typedef struct packed {
        logic       spare7;
        logic       sum;
        logic       evt;
        logic       mav;
        logic       ques;
        logic [2:0] spare_lo;
    } stat_byte_t;

    function automatic logic [BYTE_W-1:0] summary_mask(input logic [BYTE_W-1:0] en);
        logic [BYTE_W-1:0] m;
        m = en;
        m[SUM_POS] = 1'b0;
        return m;
    endfunction

    function automatic logic summary_of(input stat_byte_t s, input logic [BYTE_W-1:0] en);
        return |(s & summary_mask(en));
    endfunction

endpackage

// File: rtl/svc_mav_flag.sv
module svc_mav_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end
endmodule

// File: rtl/svc_enable_reg.sv
module svc_enable_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] en_o
);
    always_ff @(posedge clk) begin
        if (rst)
            en_o <= '0;
        else if (wr_i)
            en_o <= wdata_i;
    end
endmodule

// File: rtl/svc_req_latch.sv
module svc_req_latch (
    input  logic clk,
    input  logic rst,
    input  logic sum_i,
    input  logic panel_i,
    input  logic poll_i,
    output logic req_o
);
    logic sum_prev;
    logic sum_rise;

    assign sum_rise = sum_i & ~sum_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_prev <= 1'b0;
            req_o    <= 1'b0;
        end else begin
            sum_prev <= sum_i;
            if (sum_rise || panel_i)
                req_o <= 1'b1;
            else if (poll_i)
                req_o <= 1'b0;
        end
    end
endmodule

// File: rtl/svc_status_core.sv
module svc_status_core
    import svc_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ques_sum_i,
    input  logic              evt_sum_i,
    input  logic              mav_set_i,
    input  logic              term_sent_i,
    input  logic              panel_req_i,
    input  logic              en_wr_i,
    input  logic [BYTE_W-1:0] en_wdata_i,
    input  logic              poll_rd_i,
    output logic [BYTE_W-1:0] qry_byte_o,
    output logic [BYTE_W-1:0] poll_byte_o,
    output logic              srq_o
);
    logic              mav_q;
    logic [BYTE_W-1:0] en_q;
    logic              req_q;
    logic              sum_w;
    stat_byte_t        base_s;
    stat_byte_t        qry_s;
    stat_byte_t        poll_s;

    svc_mav_flag u_mav (
        .clk    (clk),
        .rst    (rst),
        .set_i  (mav_set_i),
        .clr_i  (term_sent_i),
        .flag_o (mav_q)
    );

    svc_enable_reg #(.W(BYTE_W)) u_en (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (en_wr_i),
        .wdata_i (en_wdata_i),
        .en_o    (en_q)
    );

    always_comb begin
        base_s          = '0;
        base_s.ques     = ques_sum_i;
        base_s.mav      = mav_q;
        base_s.evt      = evt_sum_i;
        sum_w           = summary_of(base_s, en_q);
        qry_s           = base_s;
        qry_s.sum       = sum_w;
        poll_s          = base_s;
        poll_s.sum      = req_q;
    end

    svc_req_latch u_req (
        .clk     (clk),
        .rst     (rst),
        .sum_i   (sum_w),
        .panel_i (panel_req_i),
        .poll_i  (poll_rd_i),
        .req_o   (req_q)
    );

    assign qry_byte_o  = qry_s;
    assign poll_byte_o = poll_s;
    assign srq_o       = req_q;

endmodule

// File: rtl/svc_status_chk.sv
module svc_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       ques_sum_i,
    input logic       evt_sum_i,
    input logic       mav_set_i,
    input logic       term_sent_i,
    input logic       panel_req_i,
    input logic       en_wr_i,
    input logic [7:0] en_wdata_i,
    input logic       poll_rd_i,
    input logic [7:0] qry_byte_o,
    input logic [7:0] poll_byte_o,
    input logic       srq_o
);
    p_spare_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (qry_byte_o[2:0] == 3'b000) && !qry_byte_o[7] && (poll_byte_o[2:0] == 3'b000) && !poll_byte_o[7]);

    p_live_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (qry_byte_o[3] == ques_sum_i) && (poll_byte_o[5] == evt_sum_i));

    p_mav_set_r3: assert property (@(posedge clk) disable iff (rst)
        mav_set_i |=> qry_byte_o[4]);

    p_mav_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (term_sent_i && !mav_set_i) |=> !poll_byte_o[4]);

    p_mask_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (en_wr_i && en_wdata_i == 8'h00) |=> !qry_byte_o[6]);

    p_req_set_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(qry_byte_o[6]) || panel_req_i) |=> srq_o);

    p_req_line_r7: assert property (@(posedge clk) disable iff (rst)
        srq_o == poll_byte_o[6]);

    p_poll_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (poll_rd_i && !panel_req_i && !$rose(qry_byte_o[6])) |=> !srq_o);

    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (srq_o && !poll_rd_i) |=> srq_o);
endmodule

bind svc_status_core svc_status_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ques_sum_i  (ques_sum_i),
    .evt_sum_i   (evt_sum_i),
    .mav_set_i   (mav_set_i),
    .term_sent_i (term_sent_i),
    .panel_req_i (panel_req_i),
    .en_wr_i     (en_wr_i),
    .en_wdata_i  (en_wdata_i),
    .poll_rd_i   (poll_rd_i),
    .qry_byte_o  (qry_byte_o),
    .poll_byte_o (poll_byte_o),
    .srq_o       (srq_o)
);

// File: tb/svc_status_core_test.sv
`timescale 1ns/1ps
module svc_status_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ques_sum_i = 1'b0, evt_sum_i = 1'b0;
    logic       mav_set_i = 1'b0, term_sent_i = 1'b0, panel_req_i = 1'b0;
    logic       en_wr_i = 1'b0, poll_rd_i = 1'b0;
    logic [7:0] en_wdata_i = 8'h00;
    logic [7:0] qry_byte_o, poll_byte_o;
    logic       srq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    svc_status_core uut (
        .clk(clk), .rst(rst), .ques_sum_i(ques_sum_i), .evt_sum_i(evt_sum_i),
        .mav_set_i(mav_set_i), .term_sent_i(term_sent_i), .panel_req_i(panel_req_i),
        .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i), .poll_rd_i(poll_rd_i),
        .qry_byte_o(qry_byte_o), .poll_byte_o(poll_byte_o), .srq_o(srq_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every clock edge.
    int m_en = 0, m_mav = 0, m_req = 0, m_prev = 0;

    function automatic int m_byte(int q, int e, int mav);
        return (q << 3) | (mav << 4) | (e << 5);
    endfunction

    function automatic int m_sum(int b, int en);
        return ((b & en & 8'hBF) != 0) ? 1 : 0;
    endfunction

    always begin
        int q, e, ms, te, pr, wr, wd, pl, rs, s_old, b, s_new;
        @(posedge clk);
        q = ques_sum_i; e = evt_sum_i; ms = mav_set_i; te = term_sent_i;
        pr = panel_req_i; wr = en_wr_i; wd = en_wdata_i; pl = poll_rd_i; rs = rst;
        s_old = m_sum(m_byte(q, e, m_mav), m_en);
        if (rs != 0) begin
            m_en = 0; m_mav = 0; m_req = 0; m_prev = 0;
        end else begin
            if (s_old == 1 && m_prev == 0) m_req = 1;
            else if (pr != 0) m_req = 1;
            else if (pl != 0) m_req = 0;
            m_prev = s_old;
            if (wr != 0) m_en = wd;
            if (ms != 0) m_mav = 1;
            else if (te != 0) m_mav = 0;
        end
        #2;
        if (rst == 1'b0 && !done) begin
            b = m_byte(ques_sum_i, evt_sum_i, m_mav);
            s_new = m_sum(b, m_en);
            check("R1 spare bits", {qry_byte_o[7], qry_byte_o[2:0], poll_byte_o[7], poll_byte_o[2:0]}, 0);
            check("R2 live bits", {qry_byte_o[5], qry_byte_o[3]}, {evt_sum_i, ques_sum_i});
            check("R3 R4 message bit", qry_byte_o[4], m_mav);
            check("R6 query summary", qry_byte_o, b | (s_new << 6));
            check("R7 poll byte", poll_byte_o, b | (m_req << 6));
            check("R7 request line", srq_o, m_req);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_mav();  mav_set_i = 1; step(); mav_set_i = 0; endtask
    task automatic pulse_term(); term_sent_i = 1; step(); term_sent_i = 0; endtask
    task automatic do_poll();    poll_rd_i = 1; step(); poll_rd_i = 0; endtask
    task automatic write_en(input logic [7:0] v);
        en_wr_i = 1; en_wdata_i = v; step(); en_wr_i = 0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: everything driven during reset must not stick
        #1;
        mav_set_i = 1; en_wr_i = 1; en_wdata_i = 8'hFF; panel_req_i = 1;
        repeat (4) step();
        mav_set_i = 0; en_wr_i = 0; en_wdata_i = 0; panel_req_i = 0;
        rst = 0;
        step();
        check("R9 reset query byte", qry_byte_o, 8'h00);
        check("R9 reset request line", srq_o, 0);
        ques_sum_i = 1; evt_sum_i = 1;
        step();
        check("R9 mask cleared, no summary", qry_byte_o, 8'h28);
        check("R2 live summaries", poll_byte_o, 8'h28);

        // R5: value 16 enables only bit 4
        write_en(8'd16);
        check("R5 mask 16 ignores bits 3,5", qry_byte_o[6], 0);
        pulse_mav();
        check("R3 message bit set", qry_byte_o[4], 1);
        check("R6 summary with bit 4", qry_byte_o[6], 1);
        check("R7 request not yet", srq_o, 0);
        step();
        check("R7 request after rise", srq_o, 1);
        check("R7 poll bit 6", poll_byte_o[6], 1);

        // R8: poll while the summary stays high
        do_poll();
        check("R8 poll clears", srq_o, 0);
        repeat (3) step();
        check("R8 no re-arm on level", srq_o, 0);
        check("R6 summary still high", qry_byte_o[6], 1);

        // R3: set and clear together, set wins
        mav_set_i = 1; term_sent_i = 1; step(); mav_set_i = 0; term_sent_i = 0;
        check("R3 set beats clear", qry_byte_o[4], 1);
        pulse_term();
        check("R4 terminator clears", qry_byte_o[4], 0);
        check("R6 summary drops", qry_byte_o[6], 0);

        // R5: value 48 enables bits 4 and 5
        ques_sum_i = 0; evt_sum_i = 0;
        write_en(8'd48);
        check("R5 mask 48 idle", qry_byte_o[6], 0);
        evt_sum_i = 1; #1;
        check("R5 mask 48 event bit", qry_byte_o[6], 1);
        step(); step();
        check("R7 request from event", srq_o, 1);
        do_poll();
        evt_sum_i = 0;

        // R6: mask bit 6 alone has no effect
        write_en(8'h40);
        ques_sum_i = 1; evt_sum_i = 1; pulse_mav();
        step();
        check("R6 mask bit 6 ignored", qry_byte_o[6], 0);
        check("R6 no request", srq_o, 0);

        // R7/R8: front-panel pulse, and poll with panel same cycle
        panel_req_i = 1; step(); panel_req_i = 0;
        check("R7 panel sets request", srq_o, 1);
        poll_rd_i = 1; panel_req_i = 1; step(); poll_rd_i = 0; panel_req_i = 0;
        check("R8 panel beats poll", srq_o, 1);
        do_poll();
        check("R8 poll clears after panel", srq_o, 0);

        // Random traffic checked by the model every cycle
        for (int i = 0; i < 400; i++) begin
            ques_sum_i  = ($urandom % 4) == 0;
            evt_sum_i   = ($urandom % 4) == 0;
            mav_set_i   = ($urandom % 5) == 0;
            term_sent_i = ($urandom % 5) == 0;
            panel_req_i = ($urandom % 11) == 0;
            poll_rd_i   = ($urandom % 4) == 0;
            en_wr_i     = ($urandom % 9) == 0;
            en_wdata_i  = 8'($urandom);
            step();
        end
        ques_sum_i = 0; evt_sum_i = 0; mav_set_i = 0; term_sent_i = 0;
        panel_req_i = 0; poll_rd_i = 0; en_wr_i = 0;
        step(); step();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule